// File: doc/BRIEF.md
# Transmit Reference Clock Switch Sequencer

This block sequences the move of a serial video transmitter from one reference clock to the other. One reference runs at the NTSC-family rate and the other at the PAL-family rate, nominally 148.35 MHz and 148.5 MHz. Either frequency may be wired to either input. A user asks for a switch with a one-cycle request strobe, a target select and the current video standard code. Standard-definition mode cannot switch, so that request is refused.

An accepted switch drives the PLL select output to the target and then runs a four-phase handshake with an external reconfiguration controller. The request rises, reconfiguration-done rises, the request falls, and then reconfiguration-done falls. The select stays frozen for the whole handshake. The sequencer then pulses the transmitter reset for a fixed number of cycles. Only then does the new clock count as active, and a one-cycle completion pulse is issued.

A watchdog bounds each wait on reconfiguration-done. When it expires, the sequencer drops the request, sets a sticky error and returns the select to the clock that was active before.

Top module: `refclk_switch_seq`

## Requirements
- R1: After reset, `pll_sel`, `reconf_req`, `tx_reset`, `busy`, `sw_complete`, `sw_refused` and `sw_error` are all 0. A `pll_sel` of 0 chooses the primary reference and 1 chooses the alternate.
- R2: A request sampled while idle with `std_code` = 2'b00 (standard definition) gives `sw_refused` = 1 for exactly the next cycle. `reconf_req` and `busy` stay 0 and `pll_sel` does not change.
- R3: A request sampled while idle with a non-SD code and `sw_target` equal to `pll_sel` gives `sw_complete` = 1 in the next cycle. No handshake and no reset follow.
- R4: A request sampled while idle with a non-SD code and a different target sets `reconf_req` = 1, `busy` = 1 and `pll_sel` = target in the next cycle. `pll_sel` holds steady for as long as `busy` stays high.
- R5: `reconf_req` stays 1 until `reconf_done` is sampled 1, and is 0 from the following cycle.
- R6: After the request falls, the sequencer waits for `reconf_done` to be sampled 0. From the next cycle, `tx_reset` is 1 for exactly RST_CYCLES cycles.
- R7: In the cycle after `tx_reset` falls, `sw_complete` is 1 for one cycle and `busy` is 0. The target is then the active select.
- R8: If `reconf_done` stays 0 for TIMEOUT_CYCLES cycles of a raised request, the sequencer does four things in the next cycle. It drops `reconf_req`, sets `sw_error`, clears `busy` and restores the previous `pll_sel`, with no `sw_complete`.
- R9: If `reconf_done` stays 1 for TIMEOUT_CYCLES cycles after the request falls, the same abort as in R8 follows, with no `tx_reset`.
- R10: Requests sampled while `busy` is 1 are ignored. They give no refusal and no completion, and they do not change `pll_sel`.
- R11: `sw_error` stays 1 until reset and does not block later switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | One-cycle switch request strobe |
| sw_target | input | 1 | Wanted select (0 primary, 1 alternate) |
| std_code | input | 2 | Current video standard, 2'b00 = standard definition |
| reconf_done | input | 1 | Reconfiguration-done from the controller |
| pll_sel | output | 1 | Reference clock select to transceiver and controller |
| reconf_req | output | 1 | Reconfiguration request |
| tx_reset | output | 1 | Transmitter reset pulse |
| busy | output | 1 | A switch is in progress |
| sw_complete | output | 1 | One-cycle completion pulse |
| sw_refused | output | 1 | One-cycle refusal pulse (SD mode) |
| sw_error | output | 1 | Sticky timeout error |

## Verification
The bench builds the block with TIMEOUT_CYCLES = 32 and RST_CYCLES = 3. This short watchdog brings both timeout paths within a few dozen cycles, and the short reset pulse lets every reset cycle be counted one by one. The responder delays in the vector table vary how long each handshake phase lasts. Each delay stays well below the watchdog, so a normal switch never aborts by accident.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

  typedef logic [1:0] std_code_t;
  localparam std_code_t STD_SD = 2'b00;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_REL  = 2'd2,
    ST_RST  = 2'd3
  } refsw_state_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_REFUSE = 2'd1,
    ACT_NOP    = 2'd2,
    ACT_SWITCH = 2'd3
  } refsw_action_e;

  // Classify a request presented while the sequencer is idle.
  function automatic refsw_action_e classify(logic valid, std_code_t std, logic tgt, logic cur);
    if (!valid)           return ACT_NONE;
    else if (std == STD_SD) return ACT_REFUSE;
    else if (tgt == cur)  return ACT_NOP;
    else                  return ACT_SWITCH;
  endfunction

endpackage

// File: rtl/refsw_cycle_count.sv
module refsw_cycle_count #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);

  // The owner must leave the timed phase once the window is used up (R6, R8, R9).
  assert_window_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !run);

endmodule

// File: rtl/refsw_req_decode.sv
module refsw_req_decode
  import refsw_pkg::*;
(
  input  logic          req_valid,
  input  std_code_t     std_code,
  input  logic          target,
  input  logic          current,
  output refsw_action_e action
);
  assign action = classify(req_valid, std_code, target, current);
endmodule

// File: rtl/refclk_switch_seq.sv
module refclk_switch_seq
  import refsw_pkg::*;
#(
  parameter int unsigned RST_CYCLES     = 8,
  parameter int unsigned TIMEOUT_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_req,
  input  logic       sw_target,
  input  logic [1:0] std_code,
  input  logic       reconf_done,
  output logic       pll_sel,
  output logic       reconf_req,
  output logic       tx_reset,
  output logic       busy,
  output logic       sw_complete,
  output logic       sw_refused,
  output logic       sw_error
);

  refsw_state_e  state_q, state_d;
  refsw_action_e action;
  logic sel_q, prev_q, err_q, cmpl_q, refd_q;
  logic req_exp, rel_exp, rst_exp;

  // Named internal events
  logic evt_done_seen, evt_done_clear, evt_timeout, evt_reset_end;

  refsw_req_decode u_decode (
    .req_valid (sw_req && (state_q == ST_IDLE)),
    .std_code  (std_code),
    .target    (sw_target),
    .current   (sel_q),
    .action    (action)
  );

  refsw_cycle_count #(.LIMIT(TIMEOUT_CYCLES)) u_req_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_REQ), .expired(req_exp));
  refsw_cycle_count #(.LIMIT(TIMEOUT_CYCLES)) u_rel_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_REL), .expired(rel_exp));
  refsw_cycle_count #(.LIMIT(RST_CYCLES)) u_rst_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_RST), .expired(rst_exp));

  assign evt_done_seen  = (state_q == ST_REQ) && reconf_done;
  assign evt_done_clear = (state_q == ST_REL) && !reconf_done;
  assign evt_timeout    = ((state_q == ST_REQ) && !reconf_done && req_exp) ||
                          ((state_q == ST_REL) &&  reconf_done && rel_exp);
  assign evt_reset_end  = rst_exp;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (action == ACT_SWITCH) state_d = ST_REQ;
      ST_REQ:  if (evt_done_seen) state_d = ST_REL;
               else if (evt_timeout) state_d = ST_IDLE;
      ST_REL:  if (evt_done_clear) state_d = ST_RST;
               else if (evt_timeout) state_d = ST_IDLE;
      ST_RST:  if (evt_reset_end) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      prev_q  <= 1'b0;
      err_q   <= 1'b0;
      cmpl_q  <= 1'b0;
      refd_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cmpl_q  <= (action == ACT_NOP) || evt_reset_end;
      refd_q  <= (action == ACT_REFUSE);
      if (action == ACT_SWITCH) begin
        prev_q <= sel_q;
        sel_q  <= sw_target;
      end
      if (evt_timeout) begin
        sel_q <= prev_q;
        err_q <= 1'b1;
      end
    end
  end

  assign pll_sel     = sel_q;
  assign reconf_req  = (state_q == ST_REQ);
  assign tx_reset    = (state_q == ST_RST);
  assign busy        = (state_q != ST_IDLE);
  assign sw_complete = cmpl_q;
  assign sw_refused  = refd_q;
  assign sw_error    = err_q;

  // Select frozen while a switch runs
  assert_sel_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pll_sel));

  // Request held until done is seen
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reconf_req && !reconf_done && !evt_timeout) |=> reconf_req);

  assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reconf_req && reconf_done) |=> !reconf_req);

  // Reset only after done has been released
  assert_reset_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_reset) |-> ($past(!reconf_done) && !reconf_req));

  assert_complete_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_reset) |-> (sw_complete && !busy));

  assert_timeout_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_timeout |=> (sw_error && !busy && !sw_complete && !reconf_req));

  assert_busy_no_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !sw_refused);

  assert_error_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_error |=> sw_error);

endmodule

// File: tb/test_refclk_switch_seq.sv
module test_refclk_switch_seq;

  localparam int TO = 32;
  localparam int RC = 3;
  localparam int NV = 10;
  // Outcome codes: 0 refuse, 1 no-op, 2 switch, 3 timeout waiting for done high,
  // 4 timeout waiting for done low
  // Vector: {std[1:0], target, d1[7:0], d2[7:0], outcome[2:0]}
  localparam logic [21:0] VEC [NV] = '{
    {2'd1, 1'b0, 8'd0, 8'd0, 3'd1},
    {2'd0, 1'b1, 8'd0, 8'd0, 3'd0},
    {2'd1, 1'b1, 8'd2, 8'd1, 3'd2},
    {2'd2, 1'b1, 8'd0, 8'd0, 3'd1},
    {2'd2, 1'b0, 8'd5, 8'd3, 3'd2},
    {2'd3, 1'b1, 8'd1, 8'd1, 3'd2},
    {2'd0, 1'b0, 8'd0, 8'd0, 3'd0},
    {2'd1, 1'b0, 8'd0, 8'd0, 3'd3},
    {2'd3, 1'b0, 8'd3, 8'd0, 3'd4},
    {2'd2, 1'b0, 8'd4, 8'd2, 3'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_req = 1'b0, sw_target = 1'b0, reconf_done = 1'b0;
  logic [1:0] std_code = 2'd1;
  logic pll_sel, reconf_req, tx_reset, busy, sw_complete, sw_refused, sw_error;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  logic m_sel = 1'b0;
  logic m_err = 1'b0;

  always #2 clk = ~clk;

  refclk_switch_seq #(.RST_CYCLES(RC), .TIMEOUT_CYCLES(TO)) i_refclk_switch_seq (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_target(sw_target),
    .std_code(std_code), .reconf_done(reconf_done), .pll_sel(pll_sel),
    .reconf_req(reconf_req), .tx_reset(tx_reset), .busy(busy),
    .sw_complete(sw_complete), .sw_refused(sw_refused), .sw_error(sw_error));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic run_vec(logic [21:0] v);
    logic [1:0] std = v[21:20];
    logic tgt = v[19];
    int d1 = int'(v[18:11]);
    int d2 = int'(v[10:3]);
    int oc = int'(v[2:0]);
    logic old = m_sel;
    @(negedge clk);
    sw_req = 1'b1; sw_target = tgt; std_code = std;
    @(negedge clk);
    sw_req = 1'b0;
    check("R11 error flag", sw_error, m_err);
    case (oc)
      0: begin
        check("R2 refused pulse", sw_refused, 1);
        check("R2 no request", reconf_req, 0);
        check("R2 not busy", busy, 0);
        check("R2 select kept", pll_sel, m_sel);
        @(negedge clk);
        check("R2 refusal one cycle", sw_refused, 0);
      end
      1: begin
        check("R3 immediate complete", sw_complete, 1);
        check("R3 no handshake", reconf_req | busy, 0);
        @(negedge clk);
        check("R3 no reset", tx_reset, 0);
      end
      2: begin
        check("R4 request raised", reconf_req, 1);
        check("R4 busy", busy, 1);
        check("R4 select to target", pll_sel, tgt);
        // request while busy must be ignored
        sw_req = 1'b1; sw_target = ~tgt; std_code = 2'd0;
        for (int i = 0; i < d1; i++) begin
          @(negedge clk);
          sw_req = 1'b0;
          check("R5 request held", reconf_req, 1);
          check("R10 busy request ignored", sw_refused | sw_complete, 0);
          check("R10 select unchanged", pll_sel, tgt);
        end
        reconf_done = 1'b1;
        for (int j = 0; j < d2; j++) begin
          @(negedge clk);
          check("R5 request dropped", reconf_req, 0);
          check("R6 no reset before release", tx_reset, 0);
          check("R4 select frozen", pll_sel, tgt);
        end
        reconf_done = 1'b0;
        for (int k = 0; k < RC; k++) begin
          @(negedge clk);
          check("R6 reset pulse", tx_reset, 1);
          check("R6 busy in reset", busy, 1);
        end
        @(negedge clk);
        check("R6 reset released", tx_reset, 0);
        check("R7 complete pulse", sw_complete, 1);
        check("R7 idle", busy, 0);
        check("R7 target active", pll_sel, tgt);
        @(negedge clk);
        check("R7 complete one cycle", sw_complete, 0);
        m_sel = tgt;
      end
      3: begin
        for (int i = 1; i < TO; i++) begin
          @(negedge clk);
          check("R8 request held to timeout", reconf_req, 1);
        end
        @(negedge clk);
        check("R8 request dropped", reconf_req, 0);
        check("R8 error set", sw_error, 1);
        check("R8 idle", busy, 0);
        check("R8 select restored", pll_sel, old);
        check("R8 no complete", sw_complete, 0);
        m_err = 1'b1;
      end
      default: begin
        for (int i = 0; i < d1; i++) @(negedge clk);
        reconf_done = 1'b1;
        for (int i = 0; i < TO; i++) begin
          @(negedge clk);
          check("R9 waiting release", busy & ~reconf_req & ~tx_reset, 1);
        end
        @(negedge clk);
        check("R9 error set", sw_error, 1);
        check("R9 idle", busy, 0);
        check("R9 select restored", pll_sel, old);
        check("R9 no reset", tx_reset, 0);
        reconf_done = 1'b0;
        m_err = 1'b1;
      end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 select", pll_sel, 0);
    check("R1 outputs", {reconf_req, tx_reset, busy, sw_complete, sw_refused, sw_error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", busy, 0);
    for (int n = 0; n < NV; n++) run_vec(VEC[n]);
    // Directed: error survives until reset, reset clears it
    check("R11 error still set", sw_error, 1);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset clears error", sw_error, 0);
    check("R1 reset clears select", pll_sel, 0);
    rst_n = 1'b1;
    // Directed: request with SD standard right after reset still refused
    @(negedge clk);
    sw_req = 1'b1; sw_target = 1'b1; std_code = 2'd0;
    @(negedge clk);
    sw_req = 1'b0;
    check("R2 refused after reset", sw_refused, 1);
    check("R2 select kept after reset", pll_sel, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

endmodule